// File: doc/BRIEF.md
# Sideband Error Combiner with Power-Good Masking

This block is clocked glue logic that sits between two processors, a platform health monitor and a south bridge, and routes their active-low sideband signals. For each processor it forwards the internal-error and thermal-trip indications to the monitor. A per-processor power-good enable can silence both indications, so that a processor that loses power does not report false errors. It also merges each south-bridge SMI request with a shared SMI input, and it carries NMI between a processor-side input and a shared open-drain line.

Each processor has its own shared open-drain PROCHOT line. The block pulls that line low while the processor asserts PROCHOT and its enable is high. It gives the processor a force-throttle output that goes low only when some other agent holds the line low. The line can take some time to float back high after the processor releases it. A counter of `DELAY_CYCLES` clocks therefore masks the force-throttle output after every release, so the processor's own late echo cannot cause a throttle glitch.

Every open-drain line is modelled as a pull-low enable output plus a sampled line-level input, and the block never drives a line high. All inputs pass through a synchronizer of `SYNC_STAGES` flops, and all outputs are registered. Every output therefore reflects its inputs `SYNC_STAGES`+1 clock edges later.

Top module: `sb_sideband_comb`

## Requirements
- R1: While a processor's power-good enable is low, both of its monitor outputs (error and trip) are high, whatever its error and trip inputs are.
- R2: While a processor's enable is low, its PROCHOT pull output is low, whatever its PROCHOT input is. While the enable is high, the pull output equals the inverse of the PROCHOT input.
- R3: While a processor's enable is high, each monitor output equals the matching processor input (low gives low, high gives high).
- R4: Each processor SMI output is high exactly when both its own south-bridge SMI input and the shared SMI input are high.
- R5: While the block pulls a processor's PROCHOT line low, that processor's force-throttle output is high.
- R6: Outside the mask window, a force-throttle output is low exactly when the effective PROCHOT input is high and the sampled line is low. The effective input is high when the PROCHOT input is high or the enable is low.
- R7: After the effective PROCHOT input rises, the force-throttle output stays high for DELAY_CYCLES+1 output updates. With the line held low by another agent, it goes low on clock edge DELAY_CYCLES+4 after the input change (for SYNC_STAGES=2). The counter reloads on every rise.
- R8: NMI: the NMI pull output is the inverse of the NMI input. The south-bridge NMI output is low exactly when the NMI input is high and the sampled NMI line is low.
- R9: With SYNC_STAGES=2, every output changes on the third rising clock edge after its input changes, not earlier.
- R10: While rst_ni is low, all active-low outputs are high and all pull outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pg_en_i | input | NUM_CPU | Per-processor power-good enable, high = powered |
| cpu_err_n_i | input | NUM_CPU | Processor internal-error indication, active low |
| cpu_trip_n_i | input | NUM_CPU | Processor thermal-trip indication, active low |
| mon_err_n_o | output | NUM_CPU | Error indication to the health monitor, active low |
| mon_trip_n_o | output | NUM_CPU | Thermal-trip indication to the health monitor, active low |
| sb_smi_n_i | input | NUM_CPU | South-bridge SMI request per processor, active low |
| smi_all_n_i | input | 1 | Shared SMI request, active low |
| cpu_smi_n_o | output | NUM_CPU | Combined SMI to each processor, active low |
| hot_n_i | input | NUM_CPU | Processor PROCHOT input, active low |
| hot_line_i | input | NUM_CPU | Sampled level of each shared PROCHOT line |
| hot_pull_o | output | NUM_CPU | Pull-low enable for each shared PROCHOT line |
| force_thr_n_o | output | NUM_CPU | Force-throttle output to each processor, active low |
| nmi_n_i | input | 1 | Processor-side NMI input, active low |
| nmi_line_i | input | 1 | Sampled level of the shared NMI line |
| nmi_pull_o | output | 1 | Pull-low enable for the shared NMI line |
| sb_nmi_n_o | output | 1 | NMI to the south bridge, active low |

## Verification
The assertions check the following on every cycle, using port values three edges in the past: the enable masking of the monitor outputs and of the PROCHOT pull, the copying of error inputs, the SMI combination, and the NMI relation. They also check that a force-throttle output is never low while the block itself pulls the line. A counter of quiet cycles in the checker confirms that a falling force-throttle output comes at least DELAY_CYCLES+1 cycles after the last release of the pull. Only the bench scenarios can show the following, because they depend on the line being closed through the outside world: that the loopback echo after a PROCHOT release produces no throttle glitch, the exact edge on which the masked output finally falls, and the three-edge latency.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int unsigned DEF_NUM_CPU     = 2;
  localparam int unsigned DEF_DELAY       = 11;  // ~220 ns at 50 MHz
  localparam int unsigned DEF_SYNC_STAGES = 2;

  function automatic int unsigned cnt_w(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/sb_sync.sv
module sb_sync #(
  parameter int unsigned WIDTH  = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= '1;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/sb_hot_ch.sv
module sb_hot_ch #(
  parameter int unsigned DELAY_CYCLES = sb_pkg::DEF_DELAY
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic hot_n_i,
  input  logic line_i,
  output logic pull_o,
  output logic force_n_o
);
  localparam int unsigned CW = sb_pkg::cnt_w(DELAY_CYCLES);

  logic          hot_eff, hot_q, rise, mask;
  logic [CW-1:0] cnt_q;

  // disabled processor looks like an idle PROCHOT input
  assign hot_eff = hot_n_i | ~en_i;
  assign rise    = hot_eff & ~hot_q;
  assign mask    = rise | (cnt_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hot_q     <= 1'b1;
      cnt_q     <= '0;
      pull_o    <= 1'b0;
      force_n_o <= 1'b1;
    end else begin
      hot_q <= hot_eff;
      if (rise)              cnt_q <= CW'(DELAY_CYCLES);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
      pull_o    <= ~hot_eff;
      force_n_o <= ~(hot_eff & ~line_i & ~mask);
    end
  end
endmodule

// File: rtl/sb_sideband_comb.sv
module sb_sideband_comb #(
  parameter int unsigned NUM_CPU      = sb_pkg::DEF_NUM_CPU,
  parameter int unsigned DELAY_CYCLES = sb_pkg::DEF_DELAY,
  parameter int unsigned SYNC_STAGES  = sb_pkg::DEF_SYNC_STAGES
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_CPU-1:0] pg_en_i,
  input  logic [NUM_CPU-1:0] cpu_err_n_i,
  input  logic [NUM_CPU-1:0] cpu_trip_n_i,
  output logic [NUM_CPU-1:0] mon_err_n_o,
  output logic [NUM_CPU-1:0] mon_trip_n_o,
  input  logic [NUM_CPU-1:0] sb_smi_n_i,
  input  logic               smi_all_n_i,
  output logic [NUM_CPU-1:0] cpu_smi_n_o,
  input  logic [NUM_CPU-1:0] hot_n_i,
  input  logic [NUM_CPU-1:0] hot_line_i,
  output logic [NUM_CPU-1:0] hot_pull_o,
  output logic [NUM_CPU-1:0] force_thr_n_o,
  input  logic               nmi_n_i,
  input  logic               nmi_line_i,
  output logic               nmi_pull_o,
  output logic               sb_nmi_n_o
);
  localparam int unsigned W = 6*NUM_CPU + 3;

  logic [W-1:0]       raw, syn;
  logic [NUM_CPU-1:0] en_s, err_s, trip_s, smi_s, hot_s, line_s;
  logic               smi_all_s, nmi_s, nmi_line_s;

  assign raw = {nmi_line_i, nmi_n_i, smi_all_n_i, hot_line_i, hot_n_i,
                sb_smi_n_i, cpu_trip_n_i, cpu_err_n_i, pg_en_i};

  sb_sync #(.WIDTH(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw), .q_o(syn)
  );

  assign en_s       = syn[0*NUM_CPU +: NUM_CPU];
  assign err_s      = syn[1*NUM_CPU +: NUM_CPU];
  assign trip_s     = syn[2*NUM_CPU +: NUM_CPU];
  assign smi_s      = syn[3*NUM_CPU +: NUM_CPU];
  assign hot_s      = syn[4*NUM_CPU +: NUM_CPU];
  assign line_s     = syn[5*NUM_CPU +: NUM_CPU];
  assign smi_all_s  = syn[6*NUM_CPU];
  assign nmi_s      = syn[6*NUM_CPU+1];
  assign nmi_line_s = syn[6*NUM_CPU+2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mon_err_n_o  <= '1;
      mon_trip_n_o <= '1;
      cpu_smi_n_o  <= '1;
      nmi_pull_o   <= 1'b0;
      sb_nmi_n_o   <= 1'b1;
    end else begin
      mon_err_n_o  <= err_s  | ~en_s;
      mon_trip_n_o <= trip_s | ~en_s;
      cpu_smi_n_o  <= smi_s & {NUM_CPU{smi_all_s}};
      nmi_pull_o   <= ~nmi_s;
      sb_nmi_n_o   <= ~(nmi_s & ~nmi_line_s);
    end
  end

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_cpu
    sb_hot_ch #(.DELAY_CYCLES(DELAY_CYCLES)) u_hot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (en_s[k]),
      .hot_n_i  (hot_s[k]),
      .line_i   (line_s[k]),
      .pull_o   (hot_pull_o[k]),
      .force_n_o(force_thr_n_o[k])
    );
  end
endmodule

// File: rtl/sb_sideband_chk.sv
module sb_sideband_chk #(
  parameter int unsigned NUM_CPU      = 2,
  parameter int unsigned DELAY_CYCLES = 11,
  parameter int unsigned SYNC_STAGES  = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_CPU-1:0] pg_en_i,
  input logic [NUM_CPU-1:0] cpu_err_n_i,
  input logic [NUM_CPU-1:0] cpu_trip_n_i,
  input logic [NUM_CPU-1:0] mon_err_n_o,
  input logic [NUM_CPU-1:0] mon_trip_n_o,
  input logic [NUM_CPU-1:0] sb_smi_n_i,
  input logic               smi_all_n_i,
  input logic [NUM_CPU-1:0] cpu_smi_n_o,
  input logic [NUM_CPU-1:0] hot_n_i,
  input logic [NUM_CPU-1:0] hot_line_i,
  input logic [NUM_CPU-1:0] hot_pull_o,
  input logic [NUM_CPU-1:0] force_thr_n_o,
  input logic               nmi_n_i,
  input logic               nmi_line_i,
  input logic               nmi_pull_o,
  input logic               sb_nmi_n_o
);
  localparam int unsigned LAT  = SYNC_STAGES + 1;
  localparam int unsigned QMAX = DELAY_CYCLES + 1;
  localparam int unsigned QW   = $clog2(QMAX + 1) + 1;

  logic [3:0] warm_cnt;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) warm_cnt <= '0;
    else if (warm_cnt != 4'hf) warm_cnt <= warm_cnt + 1'b1;
  end
  assign warm = (32'(warm_cnt) >= LAT);

  p_smi_and_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> cpu_smi_n_o == ($past(sb_smi_n_i, LAT) & {NUM_CPU{$past(smi_all_n_i, LAT)}}));

  p_nmi_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (nmi_pull_o == !$past(nmi_n_i, LAT)) &&
             (sb_nmi_n_o == !($past(nmi_n_i, LAT) && !$past(nmi_line_i, LAT))));

  for (genvar k = 0; k < NUM_CPU; k++) begin : g_chk
    logic [QW-1:0] quiet_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                   quiet_q <= QW'(QMAX);
      else if (hot_pull_o[k])        quiet_q <= '0;
      else if (32'(quiet_q) < QMAX)  quiet_q <= quiet_q + 1'b1;
    end

    p_err_mask_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && !$past(pg_en_i[k], LAT)) |-> (mon_err_n_o[k] && mon_trip_n_o[k]));

    p_pull_off_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && !$past(pg_en_i[k], LAT)) |-> !hot_pull_o[k]);

    p_err_copy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && $past(pg_en_i[k], LAT)) |->
        (mon_err_n_o[k] == $past(cpu_err_n_i[k], LAT)) &&
        (mon_trip_n_o[k] == $past(cpu_trip_n_i[k], LAT)));

    p_own_pull_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      hot_pull_o[k] |-> force_thr_n_o[k]);

    p_force_line_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm && !force_thr_n_o[k]) |-> !$past(hot_line_i[k], LAT));

    p_mask_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(force_thr_n_o[k]) |-> (32'(quiet_q) >= QMAX));
  end
endmodule

bind sb_sideband_comb sb_sideband_chk #(
  .NUM_CPU(NUM_CPU), .DELAY_CYCLES(DELAY_CYCLES), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pg_en_i(pg_en_i), .cpu_err_n_i(cpu_err_n_i),
  .cpu_trip_n_i(cpu_trip_n_i), .mon_err_n_o(mon_err_n_o), .mon_trip_n_o(mon_trip_n_o),
  .sb_smi_n_i(sb_smi_n_i), .smi_all_n_i(smi_all_n_i), .cpu_smi_n_o(cpu_smi_n_o),
  .hot_n_i(hot_n_i), .hot_line_i(hot_line_i), .hot_pull_o(hot_pull_o),
  .force_thr_n_o(force_thr_n_o), .nmi_n_i(nmi_n_i), .nmi_line_i(nmi_line_i),
  .nmi_pull_o(nmi_pull_o), .sb_nmi_n_o(sb_nmi_n_o)
);

// File: tb/tb_sb_sideband_comb.sv
`timescale 1ns/1ps
module tb_sb_sideband_comb;
  localparam int unsigned N = 2;
  localparam int unsigned D = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [N-1:0] pg_en_i, cpu_err_n_i, cpu_trip_n_i, mon_err_n_o, mon_trip_n_o;
  logic [N-1:0] sb_smi_n_i, cpu_smi_n_o, hot_n_i, hot_line_i, hot_pull_o, force_thr_n_o;
  logic [N-1:0] hot_ext;
  logic smi_all_n_i, nmi_n_i, nmi_line_i, nmi_pull_o, sb_nmi_n_o, nmi_ext;
  int checks = 0, errors = 0;

  always #10 clk_i = ~clk_i;

  // open-drain lines closed through the bench
  assign hot_line_i = ~(hot_pull_o | hot_ext);
  assign nmi_line_i = ~(nmi_pull_o | nmi_ext);

  sb_sideband_comb #(.NUM_CPU(N), .DELAY_CYCLES(D), .SYNC_STAGES(2)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .pg_en_i(pg_en_i), .cpu_err_n_i(cpu_err_n_i),
    .cpu_trip_n_i(cpu_trip_n_i), .mon_err_n_o(mon_err_n_o), .mon_trip_n_o(mon_trip_n_o),
    .sb_smi_n_i(sb_smi_n_i), .smi_all_n_i(smi_all_n_i), .cpu_smi_n_o(cpu_smi_n_o),
    .hot_n_i(hot_n_i), .hot_line_i(hot_line_i), .hot_pull_o(hot_pull_o),
    .force_thr_n_o(force_thr_n_o), .nmi_n_i(nmi_n_i), .nmi_line_i(nmi_line_i),
    .nmi_pull_o(nmi_pull_o), .sb_nmi_n_o(sb_nmi_n_o)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(20 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    pg_en_i = '1; cpu_err_n_i = '1; cpu_trip_n_i = '1; sb_smi_n_i = '1;
    smi_all_n_i = 1'b1; hot_n_i = '1; hot_ext = '0; nmi_n_i = 1'b1; nmi_ext = 1'b0;
    step(1);
    cpu_err_n_i = '0; hot_n_i = '0; sb_smi_n_i = '0; nmi_n_i = 1'b0;
    step(3);
    for (int k = 0; k < N; k++) begin
      chk("R10 mon_err", mon_err_n_o[k], 1'b1);
      chk("R10 smi", cpu_smi_n_o[k], 1'b1);
      chk("R10 pull", hot_pull_o[k], 1'b0);
      chk("R10 force", force_thr_n_o[k], 1'b1);
    end
    chk("R10 nmi_pull", nmi_pull_o, 1'b0);
    chk("R10 sb_nmi", sb_nmi_n_o, 1'b1);
    rst_ni = 1'b1;

    // R1 R2 R3: exhaustive over enable/err/trip/hot for both processors
    for (int c = 0; c < 64; c++) begin
      logic [5:0] v;
      v = 6'(c);
      pg_en_i = v[1:0]; cpu_err_n_i = v[3:2]; cpu_trip_n_i = v[5:4]; hot_n_i = v[3:2];
      step(8);
      for (int k = 0; k < N; k++) begin
        if (!pg_en_i[k]) begin
          chk("R1 err masked", mon_err_n_o[k], 1'b1);
          chk("R1 trip masked", mon_trip_n_o[k], 1'b1);
        end else begin
          chk("R3 err copy", mon_err_n_o[k], cpu_err_n_i[k]);
          chk("R3 trip copy", mon_trip_n_o[k], cpu_trip_n_i[k]);
        end
        chk("R2 pull", hot_pull_o[k], pg_en_i[k] & ~hot_n_i[k]);
      end
    end

    // R4: SMI combination
    for (int c = 0; c < 8; c++) begin
      logic [2:0] v;
      v = 3'(c);
      sb_smi_n_i = v[1:0]; smi_all_n_i = v[2];
      step(4);
      for (int k = 0; k < N; k++)
        chk("R4 smi", cpu_smi_n_o[k], sb_smi_n_i[k] & smi_all_n_i);
    end

    // R8: NMI with the line closed through the bench
    for (int c = 0; c < 4; c++) begin
      nmi_n_i = c[0]; nmi_ext = c[1];
      step(12);
      chk("R8 nmi_pull", nmi_pull_o, ~nmi_n_i);
      chk("R8 sb_nmi", sb_nmi_n_o, ~(nmi_n_i & nmi_ext));
    end

    // R5 R6 R7 per processor
    for (int k = 0; k < N; k++) begin
      pg_en_i = '1; hot_n_i = '1; hot_ext = '0;
      step(12);
      chk("R6 idle force", force_thr_n_o[k], 1'b1);
      hot_ext[k] = 1'b1;
      step(3);
      chk("R6 other driver", force_thr_n_o[k], 1'b0);
      hot_ext[k] = 1'b0;
      step(12);
      hot_n_i[k] = 1'b0;
      step(12);
      chk("R5 own pull", hot_pull_o[k], 1'b1);
      chk("R5 own force high", force_thr_n_o[k], 1'b1);
      // release with loopback echo: force must never glitch low
      hot_n_i[k] = 1'b1;
      for (int i = 0; i < 15; i++) begin
        step(1);
        chk("R7 no echo glitch", force_thr_n_o[k], 1'b1);
      end
      // exact mask window with line held low elsewhere
      hot_n_i[k] = 1'b0; hot_ext[k] = 1'b1;
      step(12);
      chk("R5 force high both pulling", force_thr_n_o[k], 1'b1);
      hot_n_i[k] = 1'b1;
      step(D + 3);
      chk("R7 still masked", force_thr_n_o[k], 1'b1);
      step(1);
      chk("R7 mask ends", force_thr_n_o[k], 1'b0);
      // disabled processor: input ignored, other driver still seen
      hot_ext[k] = 1'b0; pg_en_i[k] = 1'b0; hot_n_i[k] = 1'b0;
      step(12);
      chk("R2 disabled no pull", hot_pull_o[k], 1'b0);
      chk("R6 disabled idle", force_thr_n_o[k], 1'b1);
      hot_ext[k] = 1'b1;
      step(4);
      chk("R6 disabled other driver", force_thr_n_o[k], 1'b0);
      hot_ext[k] = 1'b0; pg_en_i[k] = 1'b1; hot_n_i[k] = 1'b1;
      step(12);
    end

    // R9: three-edge latency
    pg_en_i = '1; cpu_err_n_i = '1;
    step(6);
    cpu_err_n_i[0] = 1'b0;
    step(2);
    chk("R9 not yet", mon_err_n_o[0], 1'b1);
    step(1);
    chk("R9 third edge", mon_err_n_o[0], 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule